// File: doc/BRIEF.md
# TDI Line-Scan Clock Sequencer

This block produces the logic-level clock pattern for a time-delay-integration line-scan CCD. A motion encoder sends one line trigger per image line. For each trigger the block does three things in order. It steps the four imaging phases once, which moves the integrated charge forward by one TDI stage. It then opens the transfer gate for one pixel period, which dumps the summed line into the serial register. Last, it clocks the serial register with two readout phases and a sense-node reset pulse until every cell of the line has left the register.

Both configuration inputs are captured when a line starts. The line length selects 512, 1024 or 2048 image pixels. The stage count selects 6, 12, 24, 48 or 96 active stages. To enable a reduced stage count, the block holds one of four stage-select outputs low while the other three follow the last imaging phase. Every cell that leaves the serial register carries a 2-bit class flag. A valid strobe marks the image pixels. A trigger that arrives while a line is still running does not disturb that line; the block reports it as an overrun.

Top module: `tdi_seq`

## Requirements
- R1: After reset, and while no line is running, every clock, flag, strobe and overrun output is 0.
- R2: A trigger sampled in the idle state starts a line at the next clock edge. The imaging outputs then go high one at a time in the order bit 0, 1, 2, 3. Each stays high for Q_CYC clocks, and at most one is high at a time.
- R3: Stage code 0 (and codes 5 to 7) selects 96 stages, and all four stage-select bits copy imaging bit 3. Codes 1, 2, 3 and 4 select 6, 12, 24 and 48 stages. Each of these codes holds stage-select bit 0, 1, 2 or 3 (respectively) at 0, and the other three bits copy imaging bit 3.
- R4: The transfer gate is high for exactly 4*Q_CYC clocks, starting right after imaging bit 3 falls. While it is high, no imaging or readout output is high.
- R5: Length code 0, 1 or 2 (and 3) gives 512, 1024 or 2048 (and 2048) image pixels. Each line shifts out the image pixels plus 9 extra cells. One pixel period lasts 4*Q_CYC clocks.
- R6: In each pixel period, readout phase 1 is high for the first half and readout phase 2 is high for the second half. The two are never high together. The reset pulse is high during the first quarter only.
- R7: The class flag is 01 for isolation cells, 10 for shielded cells and 00 for image cells. The readout order is: 3 isolation cells (the leading cell and the two edge cells), 2 shielded cells, the image pixels, 2 shielded cells, 2 isolation cells. Outside readout the flag is 00.
- R8: The valid strobe is high exactly while an image pixel (flag 00) is being read out.
- R9: A trigger sampled while a line is running, including in its final clock, raises overrun for the next clock only. It is otherwise ignored, and the running line completes unchanged.
- R10: Changing the length or stage code while a line is running has no effect until the next line starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_trig | input | 1 | Line trigger from the motion encoder |
| len_sel | input | 2 | Line length code |
| stage_sel | input | 3 | Active stage count code |
| img_ph | output | 4 | Imaging phase enables, bit 0 = first phase |
| stage_en | output | 4 | Stage-select enables for 6/12/24/48 stages (bits 0..3) |
| xfer | output | 1 | Transfer gate enable |
| rd_ph1 | output | 1 | Readout phase 1 enable |
| rd_ph2 | output | 1 | Readout phase 2 enable |
| sn_rst | output | 1 | Sense-node reset pulse |
| pix_flag | output | 2 | Class of the cell being read out |
| line_valid | output | 1 | High for image pixels |
| overrun | output | 1 | One-clock pulse after an ignored trigger |

## Verification
Lines run with each length code and with several stage codes, including the 96-stage default and an out-of-range code. Comparing them shows whether the length and the stage mapping are decoded correctly. One line receives a second trigger together with new configuration codes in the middle of readout. This separates a correct overrun, where the trigger is ignored and the codes are held, from a restart or a live reconfiguration. Another trigger lands in the final clock of a line and is followed at once by a fresh start. This exposes off-by-one errors at the boundary between busy and idle.

// File: rtl/tdi_seq.sv
module tdi_seq #(
  parameter int BASE_LEN = 512,
  parameter int EDGE_ISO = 2,
  parameter int EDGE_SHD = 2,
  parameter int LEAD_ISO = 1,
  parameter int Q_CYC    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_trig,
  input  logic [1:0] len_sel,
  input  logic [2:0] stage_sel,
  output logic [3:0] img_ph,
  output logic [3:0] stage_en,
  output logic       xfer,
  output logic       rd_ph1,
  output logic       rd_ph2,
  output logic       sn_rst,
  output logic [1:0] pix_flag,
  output logic       line_valid,
  output logic       overrun
);
  localparam int MAX_LEN  = BASE_LEN * 4;
  localparam int FRAME    = 2 * (EDGE_ISO + EDGE_SHD) + LEAD_ISO;
  localparam int PW       = $clog2(MAX_LEN + FRAME + 1);
  localparam int QW       = $clog2(Q_CYC + 1);
  localparam int HEAD_ISO = LEAD_ISO + EDGE_ISO;
  localparam int HEAD     = HEAD_ISO + EDGE_SHD;

  localparam logic [1:0] F_ACT = 2'b00;
  localparam logic [1:0] F_ISO = 2'b01;
  localparam logic [1:0] F_SHD = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_IMG, S_XFER, S_READ} st_t;

  st_t           st;
  logic [QW-1:0] sub;
  logic [1:0]    q;
  logic [PW-1:0] pix, len_q, len_dec, last;
  logic [2:0]    stg_q;
  logic [3:0]    hold;
  logic          q_end, p_end, rd;

  assign q_end = (sub == QW'(Q_CYC - 1));
  assign p_end = q_end && (q == 2'd3);
  assign last  = len_q + PW'(FRAME - 1);
  assign rd    = (st == S_READ);

  always_comb begin
    case (len_sel)
      2'd0:    len_dec = PW'(BASE_LEN);
      2'd1:    len_dec = PW'(BASE_LEN * 2);
      default: len_dec = PW'(BASE_LEN * 4);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sub     <= '0;
      q       <= '0;
      pix     <= '0;
      len_q   <= '0;
      stg_q   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= line_trig && (st != S_IDLE);
      if (st == S_IDLE) begin
        if (line_trig) begin
          st    <= S_IMG;
          sub   <= '0;
          q     <= '0;
          pix   <= '0;
          len_q <= len_dec;
          stg_q <= stage_sel;
        end
      end else begin
        sub <= q_end ? '0 : sub + 1'b1;
        if (q_end) q <= q + 2'd1;
        if (p_end) begin
          case (st)
            S_IMG:  st <= S_XFER;
            S_XFER: st <= S_READ;
            default: begin
              if (pix == last) st <= S_IDLE;
              else pix <= pix + 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    case (stg_q)
      3'd1:    hold = 4'b0001;
      3'd2:    hold = 4'b0010;
      3'd3:    hold = 4'b0100;
      3'd4:    hold = 4'b1000;
      default: hold = 4'b0000;
    endcase
  end

  always_comb begin
    if (!rd)                                         pix_flag = F_ACT;
    else if (pix < PW'(HEAD_ISO))                    pix_flag = F_ISO;
    else if (pix < PW'(HEAD))                        pix_flag = F_SHD;
    else if (pix < PW'(HEAD) + len_q)                pix_flag = F_ACT;
    else if (pix < PW'(HEAD + EDGE_SHD) + len_q)     pix_flag = F_SHD;
    else                                             pix_flag = F_ISO;
  end

  assign img_ph     = (st == S_IMG) ? (4'b0001 << q) : 4'b0000;
  assign stage_en   = {4{img_ph[3]}} & ~hold;
  assign xfer       = (st == S_XFER);
  assign rd_ph1     = rd && !q[1];
  assign rd_ph2     = rd && q[1];
  assign sn_rst     = rd && (q == 2'd0);
  assign line_valid = rd && (pix_flag == F_ACT);
endmodule

// File: rtl/tdi_seq_chk.sv
module tdi_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_trig,
  input logic [3:0] img_ph,
  input logic [3:0] stage_en,
  input logic       xfer,
  input logic       rd_ph1,
  input logic       rd_ph2,
  input logic       sn_rst,
  input logic [1:0] pix_flag,
  input logic       line_valid,
  input logic       overrun
);
  p_img_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(img_ph));

  p_stage_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en & ~{4{img_ph[3]}}) == 4'b0000);

  p_xfer_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (img_ph == 4'b0000) && !rd_ph1 && !rd_ph2);

  p_rd_nonoverlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ph1 && rd_ph2));

  p_rst_in_ph1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sn_rst |-> rd_ph1);

  p_valid_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (pix_flag == 2'b00) && (rd_ph1 || rd_ph2));

  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(line_trig));
endmodule

bind tdi_seq tdi_seq_chk chk (
  .clk(clk), .rst_n(rst_n), .line_trig(line_trig), .img_ph(img_ph),
  .stage_en(stage_en), .xfer(xfer), .rd_ph1(rd_ph1), .rd_ph2(rd_ph2),
  .sn_rst(sn_rst), .pix_flag(pix_flag), .line_valid(line_valid),
  .overrun(overrun)
);

// File: tb/tdi_seq_test.sv
module tdi_seq_test;
  localparam int Q = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_trig = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic [2:0] stage_sel = 3'd0;
  logic [3:0] img_ph, stage_en;
  logic       xfer, rd_ph1, rd_ph2, sn_rst, line_valid, overrun;
  logic [1:0] pix_flag;

  always #2 clk = ~clk;

  tdi_seq #(.Q_CYC(Q)) uut (
    .clk(clk), .rst_n(rst_n), .line_trig(line_trig), .len_sel(len_sel),
    .stage_sel(stage_sel), .img_ph(img_ph), .stage_en(stage_en), .xfer(xfer),
    .rd_ph1(rd_ph1), .rd_ph2(rd_ph2), .sn_rst(sn_rst), .pix_flag(pix_flag),
    .line_valid(line_valid), .overrun(overrun)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int len_of(input int code);
    return (code == 0) ? 512 : (code == 1) ? 1024 : 2048;
  endfunction

  function automatic int total_of(input int len);
    return (len + 9 + 2) * 4 * Q;
  endfunction

  // behavioural reference: cycle index within the current line
  int t = -1;
  int mlen = 0;
  int mstg = 0;
  bit e_ovr = 0;
  bit done = 0;
  int done_len = 0;
  bit run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      t = -1;
      e_ovr = 0;
    end else begin
      e_ovr = line_trig && (t >= 0);
      if (t >= 0) begin
        t++;
        if (t == total_of(mlen)) begin
          t = -1;
          done = 1;
          done_len = mlen;
        end
      end else if (line_trig) begin
        t = 0;
        mlen = len_of(int'(len_sel));
        mstg = int'(stage_sel);
      end
    end
  end

  int cnt_valid = 0;
  int cnt_pix_rst = 0;

  always @(negedge clk) begin
    if (run) begin
      logic [3:0] e_img, e_ss;
      bit e_x, e_p1, e_p2, e_r, e_v;
      int e_f;
      e_img = 0; e_ss = 0; e_x = 0; e_p1 = 0; e_p2 = 0; e_r = 0; e_f = 0; e_v = 0;
      if (t >= 0) begin
        int qt;
        qt = t / Q;
        if (qt < 4) e_img = 4'b0001 << qt;
        else if (qt < 8) e_x = 1;
        else begin
          int r, p, qq;
          r = qt - 8; p = r / 4; qq = r % 4;
          e_p1 = (qq < 2); e_p2 = (qq >= 2); e_r = (qq == 0);
          if (p < 3) e_f = 1;
          else if (p < 5) e_f = 2;
          else if (p < 5 + mlen) e_f = 0;
          else if (p < 7 + mlen) e_f = 2;
          else e_f = 1;
          e_v = (e_f == 0);
        end
        for (int i = 0; i < 4; i++) begin
          bit held;
          held = (mstg == i + 1);
          e_ss[i] = held ? 1'b0 : e_img[3];
        end
      end
      chk(img_ph == e_img, "R2 imaging phases", img_ph, e_img);
      chk(stage_en == e_ss, "R3 R10 stage select", stage_en, e_ss);
      chk(xfer == e_x, "R4 transfer gate", xfer, e_x);
      chk(rd_ph1 == e_p1 && rd_ph2 == e_p2, "R6 readout phases",
          {rd_ph1, rd_ph2}, {e_p1, e_p2});
      chk(sn_rst == e_r, "R6 reset pulse", sn_rst, e_r);
      chk(int'(pix_flag) == e_f, "R7 class flag", pix_flag, e_f);
      chk(line_valid == e_v, "R8 valid strobe", line_valid, e_v);
      chk(overrun == e_ovr, "R9 overrun pulse", overrun, e_ovr);
      if (line_valid) cnt_valid++;
      if (sn_rst) cnt_pix_rst++;
      if (done) begin
        chk(cnt_valid == done_len * 4 * Q, "R5 R10 image pixel cycles",
            cnt_valid, done_len * 4 * Q);
        chk(cnt_pix_rst == (done_len + 9) * Q, "R5 cells per line",
            cnt_pix_rst / Q, done_len + 9);
        cnt_valid = 0;
        cnt_pix_rst = 0;
        done = 0;
      end
    end
  end

  task automatic start(input int lc, input int sc);
    @(negedge clk);
    len_sel = 2'(lc);
    stage_sel = 3'(sc);
    line_trig = 1'b1;
    @(negedge clk);
    line_trig = 1'b0;
  endtask

  task automatic wait_idle();
    while (t >= 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk({img_ph, stage_en, xfer, rd_ph1, rd_ph2, sn_rst, pix_flag, line_valid, overrun} == '0,
        "R1 reset state", {img_ph, stage_en}, 0);
    run = 1;
    repeat (5) @(negedge clk);

    start(0, 0);
    wait_idle();

    // R9 R10: retrigger mid-line with new codes
    start(1, 1);
    repeat (300) @(negedge clk);
    len_sel = 2'd2;
    stage_sel = 3'd4;
    line_trig = 1'b1;
    @(negedge clk);
    line_trig = 1'b0;
    wait_idle();

    start(2, 4);
    wait_idle();

    // R9: trigger in the final clock of a line, then immediate restart
    start(0, 2);
    while (t != total_of(mlen) - 1) @(negedge clk);
    line_trig = 1'b1;
    @(negedge clk);
    line_trig = 1'b0;
    chk(t < 0, "R9 final-clock trigger ignored", t, -1);
    start(3, 3);
    wait_idle();
    start(0, 7);
    wait_idle();
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule